// File: doc/BRIEF.md
# System Control Register Unit with Exception Entry and Return

This block holds the three system-control registers of a small single-cycle processor core: a status word, a cause word and the saved exception program counter. The decode stage reports a trap request as a 4-bit reason code and a valid bit. When the request is recognised, the unit records the faulting PC and the reason on the next clock edge. It also shifts the status word left so that the interrupt-enable bits are parked. In the same cycle it offers the fixed handler address to the PC-select logic.

The return-from-exception strobe works the other way. The same address output then presents the saved PC, and the status word is shifted back right on the clock edge. Software reaches the three registers through a move-to strobe, which writes a general register value on the clock edge, and a move-from strobe, which returns the selected value combinationally for write-back.

The top-level decode gates the trap-if-equal request so that it only arrives when the two source operands compare equal. This unit therefore treats a request with its valid bit low as no request at all.

Top module: `sysctl_unit`

## Requirements
- R1: A synchronous active-high reset clears the status, cause and saved-PC registers to zero.
- R2: With the read strobe high, `rdData` shows status for select 12, cause for select 13 and saved PC for select 14 in the same cycle. Any other select returns zero, and `rdData` is zero whenever the read strobe is low.
- R3: With the write strobe high and no trap or return taken, the register named by `regSel` (12, 13 or 14) takes `wrData` at the next rising edge. A write to any other select changes nothing.
- R4: A trap is taken when `excValid` is high and `causeCode` is 4'b1000 (system call), 4'b1001 (breakpoint) or 4'b1101 (trap if equal). On that edge the saved-PC register takes `pcNow`.
- R5: On a taken trap, cause bits [6:2] take the reason code zero-extended to 5 bits, and all other cause bits keep their value.
- R6: On a taken trap the status register is shifted left by 5 bits, with zeros entering from the right.
- R7: `excAddr` equals the handler vector 32'h0000_0004 in every cycle except one where a return is requested and no trap is taken.
- R8: When a return is requested and no trap is taken, `excAddr` equals the saved PC in that same cycle. The status register is shifted right by 5 at the edge, and cause and saved PC hold their values.
- R9: A request with `excValid` low, or with a code other than the three listed in R4 (including 0), changes no register.
- R10: Priority within one cycle is trap, then return, then register write. A lower-priority strobe that loses has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pcNow | input | 32 | PC of the instruction in execution |
| mtcStb | input | 1 | Move-to-register strobe |
| mfcStb | input | 1 | Move-from-register strobe |
| eretStb | input | 1 | Exception-return strobe |
| regSel | input | 5 | Register number for move-to and move-from |
| wrData | input | 32 | Value written by move-to |
| causeCode | input | 4 | Trap reason code |
| excValid | input | 1 | Trap request valid |
| rdData | output | 32 | Value returned by move-from |
| excAddr | output | 32 | Next-PC target for trap entry or return |

## Verification
`rdData` and `excAddr` are combinational from the inputs and the current register contents. The bench drives each stimulus just after a falling edge and compares both outputs before the next rising edge, within the same cycle. Register updates from a write, trap or return become visible exactly one rising edge later. The bench moves its reference model forward at that edge and observes the result through a move-from read or through `excAddr` in the following cycle, so every register effect is checked one cycle after its cause.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_CREGS = 3;

  // positions in the register array; the datapath builds a different
  // update rule for each of them
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CAUSE  = 1;
  localparam int unsigned IDX_EPC    = 2;

  localparam logic [CODE_W-1:0] CODE_SYSCALL = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_BREAK   = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_TRAPEQ  = 4'b1101;

  typedef struct packed {
    logic                 excTake;
    logic                 eretTake;
    logic [NUM_CREGS-1:0] wrHit;
    logic [NUM_CREGS-1:0] rdHit;
    logic [CODE_W-1:0]    code;
  } ctrlStb_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned SEL_STATUS = 12,
  parameter int unsigned SEL_CAUSE  = 13,
  parameter int unsigned SEL_EPC    = 14
) (
  input  logic              mtcStb,
  input  logic              mfcStb,
  input  logic              eretStb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [CODE_W-1:0] causeCode,
  input  logic              excValid,
  output ctrlStb_t          stb
);

  localparam logic [SEL_W-1:0] SelStatus = SEL_W'(SEL_STATUS);
  localparam logic [SEL_W-1:0] SelCause  = SEL_W'(SEL_CAUSE);
  localparam logic [SEL_W-1:0] SelEpc    = SEL_W'(SEL_EPC);

  logic                 codeKnown;
  logic                 wrAllowed;
  logic [NUM_CREGS-1:0] selHit;

  always_comb begin
    codeKnown = (causeCode == CODE_SYSCALL) ||
                (causeCode == CODE_BREAK)   ||
                (causeCode == CODE_TRAPEQ);
    selHit              = '0;
    selHit[IDX_STATUS]  = (regSel == SelStatus);
    selHit[IDX_CAUSE]   = (regSel == SelCause);
    selHit[IDX_EPC]     = (regSel == SelEpc);
  end

  always_comb begin
    stb.excTake  = excValid && codeKnown;
    stb.eretTake = eretStb && !stb.excTake;
    wrAllowed    = mtcStb && !stb.excTake && !eretStb;
    stb.wrHit    = wrAllowed ? selHit : '0;
    stb.rdHit    = mfcStb ? selHit : '0;
    stb.code     = causeCode;
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       PARK_SH   = 5,
  parameter int unsigned       FIELD_LSB = 2,
  parameter int unsigned       FIELD_W   = 5,
  parameter logic [DATA_W-1:0] VECTOR    = 32'h0000_0004
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] pcNow,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] excAddr,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] causeQ,
  output logic [DATA_W-1:0] epcQ
);

  localparam int unsigned PAD_W = FIELD_W - CODE_W;

  logic [DATA_W-1:0] regQ [NUM_CREGS];
  logic [FIELD_W-1:0] codeExt;

  assign codeExt = {{PAD_W{1'b0}}, stb.code};

  for (genvar i = 0; i < NUM_CREGS; i++) begin : g_creg
    if (i == IDX_STATUS) begin : g_status
      always_ff @(posedge clk) begin
        if (rst)                regQ[i] <= '0;
        else if (stb.excTake)   regQ[i] <= regQ[i] << PARK_SH;
        else if (stb.eretTake)  regQ[i] <= regQ[i] >> PARK_SH;
        else if (stb.wrHit[i])  regQ[i] <= wrData;
      end
    end else if (i == IDX_CAUSE) begin : g_cause
      always_ff @(posedge clk) begin
        if (rst)                regQ[i] <= '0;
        else if (stb.excTake)   regQ[i][FIELD_LSB +: FIELD_W] <= codeExt;
        else if (stb.wrHit[i])  regQ[i] <= wrData;
      end
    end else begin : g_epc
      always_ff @(posedge clk) begin
        if (rst)                regQ[i] <= '0;
        else if (stb.excTake)   regQ[i] <= pcNow;
        else if (stb.wrHit[i])  regQ[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_CREGS; k++) begin
      if (stb.rdHit[k]) rdData = rdData | regQ[k];
    end
  end

  assign excAddr = stb.eretTake ? regQ[IDX_EPC] : VECTOR;

  assign statusQ = regQ[IDX_STATUS];
  assign causeQ  = regQ[IDX_CAUSE];
  assign epcQ    = regQ[IDX_EPC];

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter int unsigned       DATA_W = 32,
  parameter int unsigned       SEL_W  = 5,
  parameter logic [DATA_W-1:0] VECTOR = 32'h0000_0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pcNow,
  input  logic              mtcStb,
  input  logic              mfcStb,
  input  logic              eretStb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] causeCode,
  input  logic              excValid,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] excAddr
);

  ctrlStb_t          stb;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] causeQ;
  logic [DATA_W-1:0] epcQ;

  sysctl_ctrl #(
    .SEL_W (SEL_W)
  ) u_ctrl (
    .mtcStb    (mtcStb),
    .mfcStb    (mfcStb),
    .eretStb   (eretStb),
    .regSel    (regSel),
    .causeCode (causeCode),
    .excValid  (excValid),
    .stb       (stb)
  );

  sysctl_regs #(
    .DATA_W (DATA_W),
    .VECTOR (VECTOR)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .pcNow   (pcNow),
    .wrData  (wrData),
    .rdData  (rdData),
    .excAddr (excAddr),
    .statusQ (statusQ),
    .causeQ  (causeQ),
    .epcQ    (epcQ)
  );

endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcNow,
  input logic        mtcStb,
  input logic        mfcStb,
  input logic        eretStb,
  input logic [3:0]  causeCode,
  input logic        excValid,
  input logic [31:0] rdData,
  input logic [31:0] excAddr,
  input logic [31:0] statusQ,
  input logic [31:0] causeQ,
  input logic [31:0] epcQ
);

  logic trapReq;
  assign trapReq = excValid &&
                   (causeCode == 4'b1000 || causeCode == 4'b1001 || causeCode == 4'b1101);

  a_r4_epc_load: assert property (@(posedge clk) disable iff (rst)
    trapReq |=> epcQ == $past(pcNow));

  a_r6_status_park: assert property (@(posedge clk) disable iff (rst)
    trapReq |=> statusQ == ($past(statusQ) << 5));

  a_r5_cause_field: assert property (@(posedge clk) disable iff (rst)
    trapReq |=> causeQ[6:2] == {1'b0, $past(causeCode)});

  a_r8_return_addr: assert property (@(posedge clk) disable iff (rst)
    (eretStb && !trapReq) |-> excAddr == epcQ);

  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    (trapReq || !eretStb) |-> excAddr == 32'h0000_0004);

  a_r9_no_change: assert property (@(posedge clk) disable iff (rst)
    (!trapReq && !eretStb && !mtcStb) |=>
      ($stable(statusQ) && $stable(causeQ) && $stable(epcQ)));

  a_r2_idle_read: assert property (@(posedge clk) disable iff (rst)
    !mfcStb |-> rdData == 32'h0);

endmodule

bind sysctl_unit sysctl_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pcNow     (pcNow),
  .mtcStb    (mtcStb),
  .mfcStb    (mfcStb),
  .eretStb   (eretStb),
  .causeCode (causeCode),
  .excValid  (excValid),
  .rdData    (rdData),
  .excAddr   (excAddr),
  .statusQ   (statusQ),
  .causeQ    (causeQ),
  .epcQ      (epcQ)
);

// File: tb/sysctl_unit_bench.sv
module sysctl_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcNow = '0;
  logic        mtcStb = 1'b0;
  logic        mfcStb = 1'b0;
  logic        eretStb = 1'b0;
  logic [4:0]  regSel = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  causeCode = '0;
  logic        excValid = 1'b0;
  logic [31:0] rdData;
  logic [31:0] excAddr;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  logic [31:0] mStatus = '0, mCause = '0, mEpc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_unit u_sysctl_unit (
    .clk(clk), .rst(rst), .pcNow(pcNow), .mtcStb(mtcStb), .mfcStb(mfcStb),
    .eretStb(eretStb), .regSel(regSel), .wrData(wrData),
    .causeCode(causeCode), .excValid(excValid),
    .rdData(rdData), .excAddr(excAddr)
  );

  function automatic bit isTrap(logic v, logic [3:0] c);
    return v && (c == 4'd8 || c == 4'd9 || c == 4'd13);
  endfunction

  function automatic logic [31:0] expRead(logic rd, logic [4:0] s);
    if (!rd) return 32'h0;
    case (s)
      5'd12:   return mStatus;
      5'd13:   return mCause;
      5'd14:   return mEpc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expAddr(logic er, logic v, logic [3:0] c);
    return (er && !isTrap(v, c)) ? mEpc : 32'h0000_0004;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare combinational outputs,
  // then let the rising edge act and advance the reference model
  task automatic step(logic mt, logic mf, logic er, logic [4:0] s, logic [31:0] wd,
                      logic [3:0] c, logic v, logic [31:0] pc, string tag);
    mtcStb = mt; mfcStb = mf; eretStb = er; regSel = s; wrData = wd;
    causeCode = c; excValid = v; pcNow = pc;
    #1;
    check({tag, " rdData"}, rdData, expRead(mf, s));
    check({tag, " excAddr"}, excAddr, expAddr(er, v, c));
    @(posedge clk);
    if (isTrap(v, c)) begin
      mEpc    = pc;
      mStatus = mStatus << 5;
      mCause  = (mCause & ~32'h0000_007C) | ({28'h0, c} << 2);
    end else if (er) begin
      mStatus = mStatus >> 5;
    end else if (mt) begin
      if (s == 5'd12) mStatus = wd;
      if (s == 5'd13) mCause  = wd;
      if (s == 5'd14) mEpc    = wd;
    end
    @(negedge clk);
  endtask

  task automatic rd(logic [4:0] s, string tag);
    step(1'b0, 1'b1, 1'b0, s, 32'h0, 4'h0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // dirty the inputs during reset; reset must still win
    mtcStb = 1'b1; regSel = 5'd12; wrData = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(5'd12, "R1 status");
    rd(5'd13, "R1 cause");
    rd(5'd14, "R1 epc");
    // R3 writes, R2 reads
    step(1, 0, 0, 5'd12, 32'h0000_0FFF, 0, 0, 0, "R3 wr status");
    step(1, 0, 0, 5'd13, 32'hA5A5_A5A5, 0, 0, 0, "R3 wr cause");
    step(1, 0, 0, 5'd14, 32'h1234_5678, 0, 0, 0, "R3 wr epc");
    rd(5'd12, "R3 status");
    rd(5'd13, "R3 cause");
    rd(5'd14, "R3 epc");
    step(1, 0, 0, 5'd7, 32'hDEAD_BEEF, 0, 0, 0, "R3 wr unimpl");
    rd(5'd7, "R2 unimpl select");
    rd(5'd12, "R3 status after unimpl write");
    step(0, 0, 0, 5'd13, 32'h0, 0, 0, 0, "R2 read strobe low");
    // R4 R5 R6 R7: system call
    step(0, 0, 0, 5'd0, 32'h0, 4'd8, 1, 32'h0000_0100, "R7 syscall vector");
    rd(5'd14, "R4 epc after syscall");
    rd(5'd13, "R5 cause after syscall");
    rd(5'd12, "R6 status after syscall");
    // R8 return
    step(0, 1, 1, 5'd12, 32'h0, 4'd0, 0, 32'h0, "R8 eret addr");
    rd(5'd12, "R8 status after eret");
    rd(5'd14, "R8 epc after eret");
    rd(5'd13, "R8 cause after eret");
    // breakpoint and trap-if-equal codes
    step(0, 0, 0, 5'd0, 32'h0, 4'd9, 1, 32'h0000_0200, "R4 break");
    rd(5'd13, "R5 cause after break");
    step(0, 0, 0, 5'd0, 32'h0, 4'd13, 1, 32'h0000_0300, "R4 trap equal");
    rd(5'd14, "R4 epc after trap");
    rd(5'd13, "R5 cause after trap");
    // R9 ignored requests
    step(0, 0, 0, 5'd0, 32'h0, 4'd13, 0, 32'h0000_0400, "R9 trap operands unequal");
    step(0, 0, 0, 5'd0, 32'h0, 4'd0, 1, 32'h0000_0500, "R9 code zero");
    step(0, 0, 0, 5'd0, 32'h0, 4'd5, 1, 32'h0000_0600, "R9 unknown code");
    rd(5'd14, "R9 epc unchanged");
    rd(5'd13, "R9 cause unchanged");
    rd(5'd12, "R9 status unchanged");
    // R10 priority
    step(1, 0, 1, 5'd14, 32'h7777_7777, 4'd9, 1, 32'h0000_0700, "R10 trap wins");
    rd(5'd14, "R10 epc is pc");
    rd(5'd12, "R10 status parked");
    step(1, 0, 1, 5'd13, 32'h5555_5555, 4'd0, 0, 32'h0, "R10 eret beats write");
    rd(5'd13, "R10 cause not written");
    rd(5'd12, "R10 status restored");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] s;
      logic [3:0] c;
      int pick;
      pick = $urandom_range(0, 3);
      s = (pick == 3) ? 5'($urandom) : 5'(12 + pick);
      pick = $urandom_range(0, 4);
      case (pick)
        0: c = 4'd0; 1: c = 4'd8; 2: c = 4'd9; 3: c = 4'd13;
        default: c = 4'($urandom);
      endcase
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 5) == 0), s, $urandom, c,
           ($urandom_range(0, 3) == 0), $urandom, "R10 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule